// File: doc/BRIEF.md
# Rule-Counting Category Classifier

This block sorts one input pattern into one of K categories. The pattern is a set of pixels, and every category has its own detector that sees the same pixels in the same cycle. A detector holds M rules. Each rule is a row of N comparison units, and each unit checks one chosen pixel against a threshold. A rule fires only when every unit in its row is satisfied. The detector counts its fired rules, and the category whose detector has the highest count wins.

The configuration of all units is a flat input vector. It holds, per unit, the pixel to look at, the comparison sense and the threshold. The result is the winning category index and its rule count, so that a consumer can judge confidence as count divided by M. A valid pulse marks the result. The block accepts a new pattern every cycle.

Top module: `rule_count_classifier`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid, out_cat and out_count are all 0.
- R2: A unit whose sense bit (bit PW of its field) is 0 is satisfied only when the selected pixel is strictly greater than its threshold (bits PW-1:0). A pixel equal to the threshold does not satisfy it.
- R3: A unit whose sense bit is 1 is satisfied when the selected pixel is less than or equal to its threshold.
- R4: A rule fires only when all N of its units are satisfied. One unsatisfied unit keeps the rule from firing.
- R5: A detector's count is the number of its fired rules, from 0 to M. The count of the winning detector appears on out_count.
- R6: out_cat is the index of the detector with the highest count. When several detectors share the highest count, the lowest index wins.
- R7: When no rule fires in any detector, out_cat is 0 and out_count is 0.
- R8: out_valid pulses exactly 1+clog2(K) cycles after each cycle in which in_valid is high, and is low otherwise. Patterns may arrive back to back, and each one gives its own result.
- R9: The unit field for detector k, rule r, unit n sits at unit_cfg[((k*M+r)*N+n)*UW +: UW], where UW = PIX_AW+1+PW. Bits PW+PIX_AW:PW+1 of the field select pixel p, and pixel p is pattern[p*PW +: PW]. out_count never exceeds M, and out_cat never exceeds K-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pattern on `pattern` is to be classified this cycle |
| pattern | input | (2**PIX_AW)*PW | All pixels, pixel p at bits p*PW +: PW |
| unit_cfg | input | K*M*N*(PIX_AW+1+PW) | Pixel select, sense and threshold for every unit |
| out_valid | output | 1 | Result registers hold a new result |
| out_cat | output | clog2(K) | Winning category index |
| out_count | output | clog2(M+1) | Fired-rule count of the winner |

## Verification
The bench aims at the threshold edge, where a pixel equal to the threshold separates the two senses. A design that uses the wrong comparison would fire a rule one grey level too early or too late. It builds rules in which only one of the two units passes, which catches an OR where an AND belongs. It builds ties between detectors with equal counts, where a design comparing with greater-or-equal would report the higher index. It also builds cases where no rule fires at all, and a detector with every rule firing, which shows whether the count is cut short at M. A long stream of back-to-back random patterns, each with its result computed in the bench, shows whether the valid pulse is late or early and whether results from neighbouring patterns get mixed.

// File: rtl/classifier_pkg.sv
package classifier_pkg;
  typedef enum logic {
    SENSE_ABOVE   = 1'b0,
    SENSE_AT_BELOW = 1'b1
  } sense_e;
endpackage

// File: rtl/cmp_unit.sv
module cmp_unit #(
  parameter int PIX_AW = 3,
  parameter int PW     = 8,
  localparam int NPIX  = 1 << PIX_AW,
  localparam int UW    = PIX_AW + 1 + PW
) (
  input  logic [NPIX*PW-1:0] pattern,
  input  logic [UW-1:0]      field,
  output logic               hit
);
  import classifier_pkg::*;

  logic [PW-1:0]     thr;
  logic [PIX_AW-1:0] sel;
  logic [PW-1:0]     pix;
  sense_e            sense;

  assign thr   = field[PW-1:0];
  assign sense = sense_e'(field[PW]);
  assign sel   = field[PW+1 +: PIX_AW];
  assign pix   = pattern[sel*PW +: PW];

  always_comb begin
    case (sense)
      SENSE_ABOVE:    hit = (pix > thr);
      SENSE_AT_BELOW: hit = (pix <= thr);
      default:        hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cat_detector.sv
module cat_detector #(
  parameter int M      = 4,
  parameter int N      = 2,
  parameter int PIX_AW = 3,
  parameter int PW     = 8,
  localparam int NPIX  = 1 << PIX_AW,
  localparam int UW    = PIX_AW + 1 + PW,
  localparam int CNT_W = $clog2(M + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPIX*PW-1:0]  pattern,
  input  logic [M*N*UW-1:0]   det_cfg,
  output logic [CNT_W-1:0]    count_q
);
  logic [M-1:0] rule_fire;
  logic [CNT_W-1:0] count_d;

  for (genvar r = 0; r < M; r++) begin : g_rule
    logic [N-1:0] hits;
    for (genvar n = 0; n < N; n++) begin : g_unit
      cmp_unit #(.PIX_AW(PIX_AW), .PW(PW)) u_unit (
        .pattern (pattern),
        .field   (det_cfg[(r*N+n)*UW +: UW]),
        .hit     (hits[n])
      );
    end
    assign rule_fire[r] = &hits;
  end

  always_comb begin
    count_d = '0;
    for (int r = 0; r < M; r++) begin
      count_d = count_d + CNT_W'(rule_fire[r]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end
endmodule

// File: rtl/max_stage.sv
module max_stage #(
  parameter int IN_N  = 4,
  parameter int CNT_W = 3,
  parameter int CAT_W = 2,
  localparam int OUT_N = IN_N / 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vld_in,
  input  logic [IN_N*CNT_W-1:0]  cnt_in,
  input  logic [IN_N*CAT_W-1:0]  cat_in,
  output logic                   vld_out,
  output logic [OUT_N*CNT_W-1:0] cnt_out,
  output logic [OUT_N*CAT_W-1:0] cat_out
);
  // Left entry of each pair always carries the lower indices, so the right
  // entry replaces it only on a strictly larger count.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_out <= 1'b0;
      cnt_out <= '0;
      cat_out <= '0;
    end else begin
      vld_out <= vld_in;
      for (int j = 0; j < OUT_N; j++) begin
        if (cnt_in[(2*j+1)*CNT_W +: CNT_W] > cnt_in[(2*j)*CNT_W +: CNT_W]) begin
          cnt_out[j*CNT_W +: CNT_W] <= cnt_in[(2*j+1)*CNT_W +: CNT_W];
          cat_out[j*CAT_W +: CAT_W] <= cat_in[(2*j+1)*CAT_W +: CAT_W];
        end else begin
          cnt_out[j*CNT_W +: CNT_W] <= cnt_in[(2*j)*CNT_W +: CNT_W];
          cat_out[j*CAT_W +: CAT_W] <= cat_in[(2*j)*CAT_W +: CAT_W];
        end
      end
    end
  end
endmodule

// File: rtl/rule_count_classifier.sv
module rule_count_classifier #(
  parameter int K      = 4,
  parameter int M      = 4,
  parameter int N      = 2,
  parameter int PIX_AW = 3,
  parameter int PW     = 8,
  localparam int NPIX  = 1 << PIX_AW,
  localparam int UW    = PIX_AW + 1 + PW,
  localparam int DW    = M * N * UW,
  localparam int CNT_W = $clog2(M + 1),
  localparam int LVL   = $clog2(K),
  localparam int CAT_W = LVL,
  localparam int KP    = 1 << LVL
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [NPIX*PW-1:0] pattern,
  input  logic [K*DW-1:0]    unit_cfg,
  output logic               out_valid,
  output logic [CAT_W-1:0]   out_cat,
  output logic [CNT_W-1:0]   out_count
);
  logic              det_vld_q;
  logic [K*CNT_W-1:0] det_counts;

  for (genvar k = 0; k < K; k++) begin : g_det
    cat_detector #(.M(M), .N(N), .PIX_AW(PIX_AW), .PW(PW)) u_det (
      .clk     (clk),
      .rst     (rst),
      .pattern (pattern),
      .det_cfg (unit_cfg[k*DW +: DW]),
      .count_q (det_counts[k*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) det_vld_q <= 1'b0;
    else     det_vld_q <= in_valid;
  end

  for (genvar l = 0; l <= LVL; l++) begin : g_lv
    localparam int W = KP >> l;
    logic             vld;
    logic [W*CNT_W-1:0] cnt;
    logic [W*CAT_W-1:0] cat;
    if (l == 0) begin : g_leaf
      assign vld = det_vld_q;
      for (genvar i = 0; i < KP; i++) begin : g_pad
        assign cat[i*CAT_W +: CAT_W] = CAT_W'(i);
        if (i < K) begin : g_real
          assign cnt[i*CNT_W +: CNT_W] = det_counts[i*CNT_W +: CNT_W];
        end else begin : g_zero
          assign cnt[i*CNT_W +: CNT_W] = '0;
        end
      end
    end else begin : g_node
      max_stage #(.IN_N(KP >> (l-1)), .CNT_W(CNT_W), .CAT_W(CAT_W)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .vld_in  (g_lv[l-1].vld),
        .cnt_in  (g_lv[l-1].cnt),
        .cat_in  (g_lv[l-1].cat),
        .vld_out (vld),
        .cnt_out (cnt),
        .cat_out (cat)
      );
    end
  end

  assign out_valid = g_lv[LVL].vld;
  assign out_cat   = g_lv[LVL].cat;
  assign out_count = g_lv[LVL].cnt;
endmodule

// File: rtl/classifier_checks.sv
module classifier_checks #(
  parameter int K     = 4,
  parameter int M     = 4,
  parameter int CAT_W = 2,
  parameter int CNT_W = 3,
  parameter int LVL   = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             det_vld_q,
  input logic             out_valid,
  input logic [CAT_W-1:0] out_cat,
  input logic [CNT_W-1:0] out_count
);
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_cat == '0 && out_count == '0));

  a_r8_valid_delay: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(det_vld_q, LVL));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    (int'(out_count) <= M) && (int'(out_cat) < K));

  a_r7_zero_cat: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_count == '0) |-> (out_cat == '0));
endmodule

bind rule_count_classifier classifier_checks #(
  .K(K), .M(M), .CAT_W(CAT_W), .CNT_W(CNT_W), .LVL(LVL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .det_vld_q (det_vld_q),
  .out_valid (out_valid),
  .out_cat   (out_cat),
  .out_count (out_count)
);

// File: tb/rule_count_classifier_tb.sv
module rule_count_classifier_tb;
  localparam int K = 4, M = 4, N = 2, PIX_AW = 3, PW = 8;
  localparam int NPIX = 1 << PIX_AW;
  localparam int UW = PIX_AW + 1 + PW;
  localparam int CFG_W = K*M*N*UW;
  localparam int PAT_W = NPIX*PW;
  localparam int LAT = 1 + $clog2(K);
  localparam int CLK_PERIOD = 10;
  localparam int NV = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [PAT_W-1:0] pattern = '0;
  logic [CFG_W-1:0] unit_cfg = '0;
  logic out_valid;
  logic [1:0] out_cat;
  logic [2:0] out_count;

  int total = 0, failed = 0;
  int ev[NV], ecat[NV], ecnt[NV];

  always #(CLK_PERIOD/2) clk = ~clk;

  rule_count_classifier #(.K(K), .M(M), .N(N), .PIX_AW(PIX_AW), .PW(PW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pattern(pattern),
    .unit_cfg(unit_cfg), .out_valid(out_valid), .out_cat(out_cat), .out_count(out_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_unit(input int k, input int r, input int n,
                          input int addr, input int sense, input int thr);
    unit_cfg[((k*M+r)*N+n)*UW +: UW] = {PIX_AW'(addr), 1'(sense), PW'(thr)};
  endtask

  task automatic clear_cfg();
    for (int u = 0; u < K*M*N; u++) unit_cfg[u*UW +: UW] = {PIX_AW'(0), 1'b0, PW'(255)};
  endtask

  task automatic rule_always(input int k, input int r);
    for (int n = 0; n < N; n++) set_unit(k, r, n, 0, 1, 255);
  endtask

  function automatic void model(input logic [CFG_W-1:0] c, input logic [PAT_W-1:0] p,
                                output int cat, output int cnt);
    int best = -1;
    cat = 0;
    for (int k = 0; k < K; k++) begin
      int ck = 0;
      for (int r = 0; r < M; r++) begin
        bit fire = 1'b1;
        for (int n = 0; n < N; n++) begin
          logic [UW-1:0] f = c[((k*M+r)*N+n)*UW +: UW];
          int thr = int'(f[PW-1:0]);
          int a = int'(f[PW+1 +: PIX_AW]);
          int pix = int'(p[a*PW +: PW]);
          bit h = f[PW] ? (pix <= thr) : (pix > thr);
          fire = fire & h;
        end
        if (fire) ck++;
      end
      if (ck > best) begin best = ck; cat = k; end
    end
    cnt = best;
  endfunction

  task automatic apply(input string req, input int exp_cat, input int exp_cnt);
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT-2) @(negedge clk);
    chk({req, " R8 early valid"}, int'(out_valid), 0);
    @(negedge clk);
    chk({req, " R8 valid"}, int'(out_valid), 1);
    chk({req, " cat"}, int'(out_cat), exp_cat);
    chk({req, " count"}, int'(out_count), exp_cnt);
    @(negedge clk);
    chk({req, " R8 single pulse"}, int'(out_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(out_valid), 0);
    chk("R1 cat in reset", int'(out_cat), 0);
    chk("R1 count in reset", int'(out_count), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", int'(out_valid), 0);

    // R7: nothing fires anywhere
    clear_cfg();
    pattern = '0;
    apply("R7 all zero", 0, 0);

    // R2: strict greater-than at threshold 100 on pixel 2
    set_unit(1, 0, 0, 2, 0, 100);
    set_unit(1, 0, 1, 2, 0, 100);
    pattern[2*PW +: PW] = 8'd100;
    apply("R2 equal fails", 0, 0);
    pattern[2*PW +: PW] = 8'd101;
    apply("R2 above passes", 1, 1);

    // R3: less-or-equal sense
    set_unit(1, 0, 0, 2, 1, 100);
    set_unit(1, 0, 1, 2, 1, 100);
    pattern[2*PW +: PW] = 8'd100;
    apply("R3 equal passes", 1, 1);
    pattern[2*PW +: PW] = 8'd101;
    apply("R3 above fails", 0, 0);

    // R4: one unit short keeps the rule silent (R9 field/pixel positions)
    clear_cfg();
    set_unit(2, 1, 0, 5, 0, 10);
    set_unit(2, 1, 1, 6, 0, 10);
    pattern = '0;
    pattern[5*PW +: PW] = 8'd50;
    pattern[6*PW +: PW] = 8'd5;
    apply("R4 partial rule", 0, 0);
    pattern[6*PW +: PW] = 8'd50;
    apply("R4 R9 full rule", 2, 1);

    // R5 / R9: counting up to M
    clear_cfg();
    for (int r = 0; r < 3; r++) rule_always(2, r);
    apply("R5 three rules", 2, 3);
    for (int r = 0; r < M; r++) rule_always(3, r);
    apply("R5 R9 all M rules", 3, 4);

    // R6: ties go to the lowest index
    clear_cfg();
    for (int r = 0; r < 2; r++) begin rule_always(1, r); rule_always(3, r); end
    apply("R6 tie 1 vs 3", 1, 2);
    clear_cfg();
    for (int k = 0; k < K; k++) for (int r = 0; r < M; r++) rule_always(k, r);
    apply("R6 four-way tie", 0, 4);
    clear_cfg();
    rule_always(0, 0);
    for (int r = 0; r < 3; r++) begin rule_always(1, r); rule_always(2, r); end
    apply("R6 tie 1 vs 2", 1, 3);

    // R8 / R5 / R6: back-to-back random stream
    for (int i = 0; i < NV + LAT; i++) begin
      @(negedge clk);
      if (i >= LAT) begin
        chk("R8 stream valid", int'(out_valid), ev[i-LAT]);
        if (ev[i-LAT] != 0) begin
          chk("R6 stream cat", int'(out_cat), ecat[i-LAT]);
          chk("R5 stream count", int'(out_count), ecnt[i-LAT]);
        end
      end
      if (i < NV) begin
        if (i % 40 == 0) begin
          for (int u = 0; u < K*M*N; u++)
            unit_cfg[u*UW +: UW] = {PIX_AW'($urandom % NPIX), 1'($urandom % 2), PW'($urandom % 256)};
        end
        for (int p = 0; p < NPIX; p++) pattern[p*PW +: PW] = PW'($urandom % 256);
        in_valid = (($urandom % 4) != 0);
        ev[i] = int'(in_valid);
        model(unit_cfg, pattern, ecat[i], ecnt[i]);
      end else begin
        in_valid = 1'b0;
      end
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule